// File: doc/BRIEF.md
# Segmented Eight-Opcode Processor Core

A small multicycle processor for an 8-bit, eight-opcode instruction set. It holds four general 8-bit registers, a code segment, a data segment, an 8-bit instruction pointer and a flags byte. Each instruction is one or two bytes, fetched one byte at a time over a single byte-wide memory port with a request/ready handshake. Data moves through registers with move, add and xor. Memory is reached only through a load/store opcode that addresses the data segment. A compare followed by a conditional jump gives branching. Near and far jumps redirect the fetch stream.

Every physical address is a segment value times sixteen plus an 8-bit offset, so segments overlap heavily. During reset the core takes its starting code segment and instruction pointer from two inputs. The halt opcode stops the core: it raises `halted` and stays silent on the bus until the next reset.

Top module: `seg8_core`

## Requirements
- R1: Each memory address equals segment*16 + offset. Fetches use the code segment and the instruction pointer. Loads and stores use the data segment. The first fetch after reset reads boot_cs*16 + boot_ip.
- R2: Instruction byte layout: bits 7:5 hold the opcode, bit 4 holds the mode flag, and bits 3:0 hold the first register index. Opcodes 1 to 5 take a second byte. Opcodes 0 and 6 take a second byte only when the mode flag is 1. Opcode 7 is one byte.
- R3: Opcode 1 copies, opcode 3 adds modulo 256 and opcode 4 xors into the first register. The second value is the register named by byte 2 when the mode flag is 0, and byte 2 itself when the mode flag is 1.
- R4: Opcode 2 with mode flag 0 loads the first register from data-segment offset reg[byte 2]. With mode flag 1 it stores reg[byte 2] to data-segment offset reg[first].
- R5: Register index 4 is the code segment and index 5 is the data segment. Any index of 6 or more reads as 0, and a write to it is discarded.
- R6: Opcode 5 compares the two values as unsigned numbers. It sets flags to 0x00 when they are equal, 0xFF when the first is lower, and 0x01 when the first is higher. Opcodes 3 and 4 leave flags unchanged.
- R7: Opcode 6 jumps exactly as opcode 0 does when flags equal 0x00. Otherwise it only advances past itself.
- R8: Opcode 0 with mode flag 0 loads the instruction pointer from the first register. With mode flag 1 it also loads the code segment from byte 2. The instruction pointer wraps from 0xFF to 0x00.
- R9: While a request waits for ready, the request, address, write enable and write data stay unchanged. A transfer happens on a cycle with both request and ready high.
- R10: Reset clears the general registers, the data segment and flags, and loads boot_cs and boot_ip. Opcode 7 raises halted, which then stays high with no request until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset / restart |
| boot_cs | input | 8 | Code segment loaded during reset |
| boot_ip | input | 8 | Instruction pointer loaded during reset |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 13 | Physical byte address |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or completes the request |
| halted | output | 1 | Core stopped by the halt opcode |

## Verification
Flags never appear at a port. Their value can only be inferred from whether a following conditional jump is taken. The stimulus therefore runs every compare outcome into a conditional jump that points back to code that has already run. A wrongly taken branch repeats a store, and the scoreboard rejects it. Adds and xors are placed between a compare and its branch to show that they leave flags alone. A boot pointer of 0xFE makes the instruction pointer wrap partway through the first instruction. The memory model inserts pseudo-random ready stalls, so every request is held across waiting cycles.

// File: rtl/seg8_core.sv
module seg8_core #(
  parameter int DW = 8,
  parameter int SEG_SHIFT = 4,
  localparam int AW = DW + SEG_SHIFT + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] boot_cs,
  input  logic [DW-1:0] boot_ip,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          halted
);
  localparam logic [2:0] S_F1 = 3'd0, S_F2 = 3'd1, S_EX = 3'd2, S_MEM = 3'd3, S_HLT = 3'd4;
  localparam logic [2:0] OP_JMP = 3'd0, OP_MOV = 3'd1, OP_LDST = 3'd2, OP_ADD = 3'd3,
                         OP_XOR = 3'd4, OP_CMP = 3'd5, OP_JEQ = 3'd6, OP_HLT = 3'd7;

  logic [2:0]    state;
  logic [DW-1:0] ir, op2, ip, cs, ds, flags;
  logic [DW-1:0] gpr [4];
  logic [DW-1:0] va, vr2, vb, wdat;
  logic          wen;

  wire [2:0] opc = ir[DW-1:DW-3];
  wire       mode = ir[DW-4];
  wire [3:0] r1i = ir[3:0];

  function automatic logic [AW-1:0] phys(input logic [DW-1:0] seg, input logic [DW-1:0] off);
    return (AW'(seg) << SEG_SHIFT) + AW'(off);
  endfunction

  function automatic logic two_byte(input logic [DW-1:0] b);
    logic [2:0] o;
    o = b[DW-1:DW-3];
    return (o >= OP_MOV && o <= OP_CMP) || ((o == OP_JMP || o == OP_JEQ) && b[DW-4]);
  endfunction

  always_comb begin
    case (r1i)
      4'd0, 4'd1, 4'd2, 4'd3: va = gpr[r1i[1:0]];
      4'd4: va = cs;
      4'd5: va = ds;
      default: va = '0;
    endcase
    case (op2)
      DW'(0), DW'(1), DW'(2), DW'(3): vr2 = gpr[op2[1:0]];
      DW'(4): vr2 = cs;
      DW'(5): vr2 = ds;
      default: vr2 = '0;
    endcase
  end

  assign vb = mode ? op2 : vr2;

  always_comb begin
    wen  = 1'b0;
    wdat = vb;
    if (state == S_EX) begin
      case (opc)
        OP_MOV: wen = 1'b1;
        OP_ADD: begin wen = 1'b1; wdat = va + vb; end
        OP_XOR: begin wen = 1'b1; wdat = va ^ vb; end
        default: wen = 1'b0;
      endcase
    end else if (state == S_MEM && !mode && mem_ready) begin
      wen  = 1'b1;
      wdat = mem_rdata;
    end
  end

  assign mem_req   = (state == S_F1) || (state == S_F2) || (state == S_MEM);
  assign mem_we    = (state == S_MEM) && mode;
  assign mem_wdata = vr2;
  assign mem_addr  = (state == S_MEM) ? phys(ds, mode ? va : vr2) : phys(cs, ip);
  assign halted    = (state == S_HLT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_F1;
      cs    <= boot_cs;
      ip    <= boot_ip;
      ds    <= '0;
      flags <= '0;
      ir    <= '0;
      op2   <= '0;
      for (int i = 0; i < 4; i++) gpr[i] <= '0;
    end else begin
      case (state)
        S_F1: if (mem_ready) begin
          ir    <= mem_rdata;
          ip    <= ip + 1'b1;
          state <= two_byte(mem_rdata) ? S_F2 : S_EX;
        end
        S_F2: if (mem_ready) begin
          op2   <= mem_rdata;
          ip    <= ip + 1'b1;
          state <= S_EX;
        end
        S_EX: begin
          state <= S_F1;
          case (opc)
            OP_JMP: begin
              ip <= va;
              if (mode) cs <= op2;
            end
            OP_JEQ: if (flags == '0) begin
              ip <= va;
              if (mode) cs <= op2;
            end
            OP_LDST: state <= S_MEM;
            OP_CMP: flags <= (va == vb) ? '0 : (va < vb) ? '1 : DW'(1);
            OP_HLT: state <= S_HLT;
            default: ;
          endcase
        end
        S_MEM: if (mem_ready) state <= S_F1;
        default: state <= S_HLT;
      endcase
      if (wen) begin
        if (r1i < 4'd4) gpr[r1i[1:0]] <= wdat;
        else if (r1i == 4'd4) cs <= wdat;
        else if (r1i == 4'd5) ds <= wdat;
      end
    end
  end
endmodule

// File: rtl/seg8_core_chk.sv
module seg8_core_chk #(
  parameter int DW = 8,
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          halted,
  input logic [2:0]    state,
  input logic [2:0]    opc,
  input logic [DW-1:0] flags,
  input logic [DW-1:0] ip
);
  wire in_ex = (state == 3'd2);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R10
  AST_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    flags == '0 || flags == DW'(1) || flags == '1); // R6
  AST_ARITH_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ex && (opc == 3'd3 || opc == 3'd4) |=> $stable(flags)); // R6
  AST_JEQ_FALLS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    in_ex && opc == 3'd6 && flags != '0 |=> ip == $past(ip)); // R7
  AST_WRITE_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req && !halted); // R4
endmodule

bind seg8_core seg8_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .halted(halted), .state(state),
  .opc(opc), .flags(flags), .ip(ip)
);

// File: tb/seg8_core_bench.sv
`timescale 1ns/1ps
module seg8_core_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  boot_cs = 0, boot_ip = 0;
  logic        mem_req, mem_we, mem_ready = 0;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = 0;
  logic        halted;

  always #4 clk = ~clk;

  seg8_core u_seg8_core (
    .clk(clk), .rst_n(rst_n), .boot_cs(boot_cs), .boot_ip(boot_ip),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .halted(halted)
  );

  typedef struct { logic [12:0] a; logic [7:0] d; string tag; } wr_t;
  wr_t exp_q[$];
  logic [7:0] mem [0:4095];
  int total = 0, bad = 0, hs_err = 0;
  int unsigned pp = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic pend = 0;
  logic [12:0] pend_addr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [12:0] a, input logic [7:0] d, input string tag);
    wr_t w;
    w.a = a; w.d = d; w.tag = tag;
    exp_q.push_back(w);
  endtask

  // memory model with random stalls, and scoreboard monitor for stores (R9 stalls)
  always @(negedge clk) begin
    logic rdy;
    wr_t w;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdy = rst_n && mem_req && (lfsr[1] | lfsr[4]);
    if (!rst_n) pend = 0;
    if (pend && (!mem_req || mem_addr != pend_addr)) hs_err++;
    pend = mem_req && !rdy && rst_n;
    pend_addr = mem_addr;
    mem_ready <= rdy;
    mem_rdata <= mem[mem_addr[11:0]];
    if (rdy && mem_we) begin
      mem[mem_addr[11:0]] = mem_wdata;
      if (exp_q.size() == 0)
        chk(0, "R4", "unexpected store addr/data", {11'd0, mem_addr, mem_wdata}, 0);
      else begin
        w = exp_q.pop_front();
        chk(mem_addr == w.a && mem_wdata == w.d, w.tag, "store addr/data",
            {11'd0, mem_addr, mem_wdata}, {11'd0, w.a, w.d});
      end
    end
  end

  function automatic logic [7:0] ib(input int op, input int m, input int r);
    return {op[2:0], m[0], r[3:0]};
  endfunction
  task automatic put(input logic [7:0] b); mem[pp[11:0]] = b; pp++; endtask
  task automatic at(input int unsigned a); pp = a; endtask
  task automatic movi(input int r, input logic [7:0] v); put(ib(1,1,r)); put(v); endtask
  task automatic movr(input int r, input int s); put(ib(1,0,r)); put(8'(s)); endtask
  task automatic addi(input int r, input logic [7:0] v); put(ib(3,1,r)); put(v); endtask
  task automatic addr(input int r, input int s); put(ib(3,0,r)); put(8'(s)); endtask
  task automatic xori(input int r, input logic [7:0] v); put(ib(4,1,r)); put(v); endtask
  task automatic xorr(input int r, input int s); put(ib(4,0,r)); put(8'(s)); endtask
  task automatic cmpi(input int r, input logic [7:0] v); put(ib(5,1,r)); put(v); endtask
  task automatic cmpr(input int r, input int s); put(ib(5,0,r)); put(8'(s)); endtask
  task automatic store(input int ra, input int rs); put(ib(2,1,ra)); put(8'(rs)); endtask
  task automatic load(input int rd, input int ra); put(ib(2,0,rd)); put(8'(ra)); endtask
  task automatic jmpn(input int r); put(ib(0,0,r)); endtask
  task automatic jmpf(input int r, input logic [7:0] s); put(ib(0,1,r)); put(s); endtask
  task automatic jen(input int r); put(ib(6,0,r)); endtask
  task automatic jef(input int r, input logic [7:0] s); put(ib(6,1,r)); put(s); endtask
  task automatic hlt(); put(ib(7,0,0)); endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    exp_q.delete();
  endtask

  task automatic run(input logic [7:0] c, input logic [7:0] i, input string tag);
    int n;
    bit quiet;
    @(negedge clk);
    rst_n = 0; boot_cs = c; boot_ip = i;
    repeat (3) @(negedge clk);
    chk(!halted, "R10", "halted during reset", halted, 0);
    #1 rst_n = 1;
    chk(mem_req && mem_addr == {5'd0, c} * 13'd16 + {5'd0, i}, "R1", "first fetch address",
        mem_addr, {5'd0, c} * 13'd16 + {5'd0, i});
    n = 0;
    while (!halted && n < 4000) begin @(negedge clk); n++; end
    chk(halted, "R10", "halted after program", halted, 1);
    chk(exp_q.size() == 0, tag, "stores still expected", exp_q.size(), 0);
    chk(hs_err == 0, "R9", "request dropped or changed while waiting", hs_err, 0);
    hs_err = 0;
    quiet = 1;
    repeat (6) begin @(negedge clk); quiet &= !mem_req && halted; end
    chk(quiet, "R10", "bus silent and halted after stop", quiet, 1);
  endtask

  initial begin
    #(8 * 190000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // program 1: R2 R3 R4 R5 data movement
    clear_mem();
    mem[12'h310] = 8'h9C;
    at(0);
    movi(5, 8'h30); movi(0, 8'h05); movi(1, 8'hFE);
    addi(1, 8'h05); xori(0, 8'hFF);
    movi(2, 0); store(2, 1);          expect_wr(13'h300, 8'h03, "R3");
    movi(2, 1); store(2, 0);          expect_wr(13'h301, 8'hFA, "R3");
    addr(0, 1); movr(3, 0); xorr(3, 1);
    movi(2, 2); store(2, 3);          expect_wr(13'h302, 8'hFE, "R3");
    movi(2, 3); store(2, 5);          expect_wr(13'h303, 8'h30, "R5");
    movi(2, 4); store(2, 7);          expect_wr(13'h304, 8'h00, "R5");
    movi(6, 8'h55); movi(2, 5); store(2, 6); expect_wr(13'h305, 8'h00, "R5");
    movi(2, 8'h10); load(0, 2);
    movi(2, 6); store(2, 0);          expect_wr(13'h306, 8'h9C, "R4");
    hlt();
    run(8'h00, 8'h00, "R2");

    // program 2: R6 R7 compare and conditional jump
    clear_mem();
    at(12'h014);
    movi(5, 8'h30); movi(0, 7); cmpi(0, 7); movi(3, 8'h40); jen(3);
    movi(1, 8'hBB); movi(2, 8'h20); store(2, 1); hlt();
    at(12'h050);
    movi(1, 8'hAA); movi(2, 8'h20); store(2, 1);  expect_wr(13'h320, 8'hAA, "R7");
    cmpi(0, 9); jen(3);
    movi(1, 8'hCC); movi(2, 8'h21); store(2, 1);  expect_wr(13'h321, 8'hCC, "R6");
    addi(0, 1); jen(3);
    movi(1, 8'hDD); movi(2, 8'h22); store(2, 1);  expect_wr(13'h322, 8'hDD, "R6");
    cmpi(0, 3); jen(3);
    movi(1, 8'h77); movi(2, 8'h23); store(2, 1);  expect_wr(13'h323, 8'h77, "R6");
    movi(1, 8); cmpr(0, 1); xori(2, 1); movi(3, 8); jef(3, 8'h20);
    movi(1, 8'h66); store(2, 1); hlt();
    at(12'h208);
    movi(1, 8'hEE); movi(2, 8'h24); store(2, 1);  expect_wr(13'h324, 8'hEE, "R7");
    hlt();
    run(8'h01, 8'h04, "R7");

    // program 3: R8 near/far jumps and pointer wrap
    clear_mem();
    at(12'h14E);
    movi(5, 8'h30);
    at(12'h050);
    movi(0, 8'h11); movi(1, 2); jmpf(1, 8'h40);
    at(12'h402);
    movi(2, 8'h30); store(2, 0);      expect_wr(13'h330, 8'h11, "R8");
    movi(3, 8'h10); jmpn(3);
    movi(0, 8'h99); store(2, 0); hlt();
    at(12'h410);
    movi(2, 8'h31); store(2, 4);      expect_wr(13'h331, 8'h40, "R8");
    hlt();
    run(8'h05, 8'hFE, "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule